// File: doc/BRIEF.md
# Network Controller Command and Status Register

This block is the 16-bit command and status word of a packet network controller. A host reaches it over a plain register port (select, write enable, write data, registered read data). The controller engine reaches it through single-cycle event pulses and gets back level commands: start, initialise, stop, transmit demand, receiver enable and transmitter enable. An interrupt request rises when an interrupting condition is pending and interrupts are enabled. A further output permits access to the controller's other configuration registers, and it is true only while the controller is stopped.

Seven sticky condition flags are set by engine events and cleared when the host writes 1 to them. Two read-only summary bits are built from these flags. The error summary covers the four error flags. The interrupt summary covers every flag except the heartbeat failure flag. The three command bits interlock. A stop request clears everything else and beats a simultaneous initialise or start. Initialise and start are accepted only while stopped, and accepting either one leaves the stopped state.

Top module: `netctl_csr`

Bit map: 15 error summary, 14 babble, 13 heartbeat failure, 12 missed packet, 11 memory timeout, 10 receive done, 9 transmit done, 8 init done, 7 interrupt summary, 6 interrupt enable, 5 receiver on, 4 transmitter on, 3 transmit demand, 2 stop, 1 start, 0 initialise.

## Requirements
- R1: After a cycle with `rst` high, the word reads 0x0004: only stop (bit 2) is set, `cfg_access` and `cmd_stop` are 1, and every other output is 0.
- R2: The cycle after `csr_sel` is high, `csr_rdata` shows the word as it stood in the select cycle, before any write in that cycle takes effect. While `csr_sel` is low, `csr_rdata` reads 0. A read with `csr_we` low changes no bit.
- R3: Bit 15 reads as the OR of bits 14, 13, 12 and 11. Writes to bit 15 have no effect.
- R4: Bit 7 reads as the OR of bits 14, 12, 11, 10, 9 and 8. Bit 13 has no effect on bit 7.
- R5: Bit 6 is a plain read/write enable. `irq` is high in the cycle after a cycle in which bit 7 and bit 6 are both 1, and is low otherwise.
- R6: An event pulse sets its flag (babble bit 14, heartbeat bit 13, missed bit 12, memory timeout bit 11, receive done bit 10, transmit done bit 9, init done bit 8) from the next cycle on. Writing 1 to a flag clears it, and writing 0 leaves it alone. An event in the same cycle as a clearing write leaves the flag set.
- R7: Writing 1 to bit 2 sets stop and clears every other bit. This includes initialise and start written in the same cycle, and events arriving in the same cycle.
- R8: Writing 1 to bit 0 or bit 1 sets that bit and clears stop only if stop was set. Otherwise the write is ignored. Writing 0 to bits 0 to 2 has no effect. `cmd_init`, `cmd_start` and `cmd_stop` follow bits 0, 1 and 2.
- R9: Bits 5 and 4 (`rx_enable`, `tx_enable`) become set one cycle after start and init done are first both 1. Each is set unless its disable input (`rx_disable`, `tx_disable`) is 1 in that cycle.
- R10: While the memory timeout flag is 1, bits 5 and 4 are cleared at the next edge. A `ev_tx_fatal` pulse clears bit 4 at the next edge.
- R11: Writing 1 to bit 3 sets transmit demand (`cmd_tdmd`). An `ev_tdmd_ack` clears it at the next edge, unless a write of 1 to bit 3 comes in the same cycle.
- R12: `cfg_access` is 1 exactly while stop is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up or I/O reset) |
| csr_sel | input | 1 | Register select |
| csr_we | input | 1 | Write enable, qualified by select |
| csr_wdata | input | 16 | Write data |
| csr_rdata | output | 16 | Registered read data |
| ev_babble | input | 1 | Transmitter ran past maximum frame length |
| ev_hb_fail | input | 1 | Heartbeat (collision test) missing after transmit |
| ev_missed | input | 1 | Frame lost for lack of a receive buffer |
| ev_mem_timeout | input | 1 | Buffer memory failed to respond |
| ev_rx_done | input | 1 | Receive descriptor updated |
| ev_tx_done | input | 1 | Transmit descriptor updated |
| ev_init_done | input | 1 | Initialisation block loaded |
| ev_tdmd_ack | input | 1 | Engine has taken the transmit demand |
| ev_tx_fatal | input | 1 | Underflow, buffer or retry failure in the transmitter |
| rx_disable | input | 1 | Receive-disable mode flag |
| tx_disable | input | 1 | Transmit-disable mode flag |
| cmd_init | output | 1 | Initialise command level |
| cmd_start | output | 1 | Start command level |
| cmd_stop | output | 1 | Stop command level |
| cmd_tdmd | output | 1 | Transmit demand level |
| rx_enable | output | 1 | Receiver on |
| tx_enable | output | 1 | Transmitter on |
| irq | output | 1 | Interrupt request |
| cfg_access | output | 1 | Permits access to the other configuration registers |

## Verification
Every register bit, and every level output that mirrors one, changes at the first edge after the write or event that causes it. The read word and `irq` arrive one edge after the state they report. The receiver and transmitter enables arrive one edge after start and init done are both visible, so a start written after init done shows up two edges after the write. The bench drives inputs and compares every output at the falling edge. Its behavioural model advances at each rising edge using the same latencies, so each comparison lands on the cycle the result is due.

// File: rtl/netctl_csr_pkg.sv
package netctl_csr_pkg;
  localparam int CSR_W     = 16;
  localparam int NUM_FLAGS = 7;

  localparam int B_INIT    = 0;
  localparam int B_STRT    = 1;
  localparam int B_STOP    = 2;
  localparam int B_TDMD    = 3;
  localparam int B_TXON    = 4;
  localparam int B_RXON    = 5;
  localparam int B_INEA    = 6;
  localparam int B_INTR    = 7;
  localparam int B_FLAG_LO = 8;
  localparam int B_ERR     = 15;

  localparam int F_IDON = 0;
  localparam int F_TINT = 1;
  localparam int F_RINT = 2;
  localparam int F_MERR = 3;
  localparam int F_MISS = 4;
  localparam int F_CERR = 5;
  localparam int F_BABL = 6;

  localparam logic [NUM_FLAGS-1:0] ERR_MASK  = 7'b111_1000;
  localparam logic [NUM_FLAGS-1:0] INTR_MASK = 7'b101_1111;
endpackage

// File: rtl/netctl_flag_bank.sv
module netctl_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] w1c,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr_all) flags_q[i] <= 1'b0;
      else if (ev[i])     flags_q[i] <= 1'b1;
      else if (w1c[i])    flags_q[i] <= 1'b0;
    end
  end

  // R6: an event is captured, and a one-write without an event clears
  p_ev_sets_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> ((flags_q & $past(ev)) == $past(ev)));
  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> ((flags_q & $past(w1c & ~ev)) == '0));
endmodule

// File: rtl/netctl_cmd_ctrl.sv
module netctl_cmd_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_init,
  input  logic wr_strt,
  input  logic wr_stop,
  input  logic wr_tdmd,
  input  logic wr_inea,
  input  logic tdmd_ack,
  output logic clr_all,
  output logic init_q,
  output logic strt_q,
  output logic stop_q,
  output logic tdmd_q,
  output logic inea_q
);
  logic go_ok;

  assign clr_all = wr_en & wr_stop;
  assign go_ok   = wr_en & stop_q & (wr_init | wr_strt) & ~wr_stop;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      stop_q <= 1'b1;
      init_q <= 1'b0;
      strt_q <= 1'b0;
      tdmd_q <= 1'b0;
      inea_q <= 1'b0;
    end else begin
      if (go_ok) begin
        init_q <= init_q | wr_init;
        strt_q <= strt_q | wr_strt;
        stop_q <= 1'b0;
      end
      if (wr_en) inea_q <= wr_inea;
      if (wr_en && wr_tdmd) tdmd_q <= 1'b1;
      else if (tdmd_ack)    tdmd_q <= 1'b0;
    end
  end

  // R7: stop excludes the run commands and wipes state when written
  p_stop_excl_r7: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> !(init_q || strt_q));
  p_stop_wipe_r7: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (stop_q && !init_q && !strt_q && !tdmd_q && !inea_q));
  // R8: a run command only appears out of the stopped state
  p_go_gate_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(init_q) || $rose(strt_q)) |-> $past(stop_q));
  // R11: an acknowledge without a new demand write drops the demand
  p_tdmd_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (tdmd_ack && !wr_en) |=> !tdmd_q);
endmodule

// File: rtl/netctl_link_en.sv
module netctl_link_en (
  input  logic clk,
  input  logic rst,
  input  logic clr_all,
  input  logic strt,
  input  logic idon,
  input  logic merr,
  input  logic tx_fatal,
  input  logic rx_dis,
  input  logic tx_dis,
  output logic rx_on,
  output logic tx_on
);
  logic ready, ready_q;

  assign ready = strt & idon;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      rx_on   <= 1'b0;
      tx_on   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready;
      if (merr) begin
        rx_on <= 1'b0;
        tx_on <= 1'b0;
      end else begin
        if (ready && !ready_q) begin
          if (!rx_dis) rx_on <= 1'b1;
          if (!tx_dis) tx_on <= 1'b1;
        end
        if (tx_fatal) tx_on <= 1'b0;
      end
    end
  end

  // R10: memory timeout and transmit failures shut the paths
  p_merr_off_r10: assert property (@(posedge clk) disable iff (rst)
    merr |=> (!rx_on && !tx_on));
  p_fatal_off_r10: assert property (@(posedge clk) disable iff (rst)
    tx_fatal |=> !tx_on);
  // R9: an enable only rises after start and init done
  p_rx_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_on) |-> $past(strt && idon));
  p_tx_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_on) |-> $past(strt && idon));
endmodule

// File: rtl/netctl_csr.sv
module netctl_csr
  import netctl_csr_pkg::*;
#(
  parameter int DATA_W = CSR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_sel,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              ev_babble,
  input  logic              ev_hb_fail,
  input  logic              ev_missed,
  input  logic              ev_mem_timeout,
  input  logic              ev_rx_done,
  input  logic              ev_tx_done,
  input  logic              ev_init_done,
  input  logic              ev_tdmd_ack,
  input  logic              ev_tx_fatal,
  input  logic              rx_disable,
  input  logic              tx_disable,
  output logic              cmd_init,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_tdmd,
  output logic              rx_enable,
  output logic              tx_enable,
  output logic              irq,
  output logic              cfg_access
);
  localparam int FLAG_HI = B_FLAG_LO + NUM_FLAGS - 1;

  logic                 wr_en, clr_all;
  logic                 init_q, strt_q, stop_q, tdmd_q, inea_q;
  logic                 rx_on, tx_on, err_sum, intr_sum, irq_q;
  logic [NUM_FLAGS-1:0] ev_vec, w1c_vec, flags_q;
  logic [DATA_W-1:0]    word, rdata_q;
  logic                 unused_wbits;

  assign wr_en = csr_sel & csr_we;

  always_comb begin
    ev_vec         = '0;
    ev_vec[F_IDON] = ev_init_done;
    ev_vec[F_TINT] = ev_tx_done;
    ev_vec[F_RINT] = ev_rx_done;
    ev_vec[F_MERR] = ev_mem_timeout;
    ev_vec[F_MISS] = ev_missed;
    ev_vec[F_CERR] = ev_hb_fail;
    ev_vec[F_BABL] = ev_babble;
  end

  assign w1c_vec      = wr_en ? csr_wdata[FLAG_HI:B_FLAG_LO] : '0;
  assign unused_wbits = ^{csr_wdata[B_ERR], csr_wdata[B_INTR],
                          csr_wdata[B_RXON], csr_wdata[B_TXON]};

  netctl_cmd_ctrl u_cmd (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_init  (csr_wdata[B_INIT]),
    .wr_strt  (csr_wdata[B_STRT]),
    .wr_stop  (csr_wdata[B_STOP]),
    .wr_tdmd  (csr_wdata[B_TDMD]),
    .wr_inea  (csr_wdata[B_INEA]),
    .tdmd_ack (ev_tdmd_ack),
    .clr_all  (clr_all),
    .init_q   (init_q),
    .strt_q   (strt_q),
    .stop_q   (stop_q),
    .tdmd_q   (tdmd_q),
    .inea_q   (inea_q)
  );

  netctl_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .clr_all (clr_all),
    .ev      (ev_vec),
    .w1c     (w1c_vec),
    .flags_q (flags_q)
  );

  netctl_link_en u_link (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (clr_all),
    .strt     (strt_q),
    .idon     (flags_q[F_IDON]),
    .merr     (flags_q[F_MERR]),
    .tx_fatal (ev_tx_fatal),
    .rx_dis   (rx_disable),
    .tx_dis   (tx_disable),
    .rx_on    (rx_on),
    .tx_on    (tx_on)
  );

  assign err_sum  = |(flags_q & ERR_MASK);
  assign intr_sum = |(flags_q & INTR_MASK);

  always_comb begin
    word                     = '0;
    word[B_ERR]              = err_sum;
    word[FLAG_HI:B_FLAG_LO]  = flags_q;
    word[B_INTR]             = intr_sum;
    word[B_INEA]             = inea_q;
    word[B_RXON]             = rx_on;
    word[B_TXON]             = tx_on;
    word[B_TDMD]             = tdmd_q;
    word[B_STOP]             = stop_q;
    word[B_STRT]             = strt_q;
    word[B_INIT]             = init_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= csr_sel ? word : '0;
      irq_q   <= intr_sum & inea_q;
    end
  end

  assign csr_rdata  = rdata_q;
  assign irq        = irq_q;
  assign cmd_init   = init_q;
  assign cmd_start  = strt_q;
  assign cmd_stop   = stop_q;
  assign cmd_tdmd   = tdmd_q;
  assign rx_enable  = rx_on;
  assign tx_enable  = tx_on;
  assign cfg_access = stop_q;

  // R5: a pending, enabled interrupt reaches the request pin next cycle
  p_irq_r5: assert property (@(posedge clk) disable iff (rst)
    (intr_sum && inea_q) |=> irq);
  // R2: an unselected cycle returns zero read data
  p_rd_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !csr_sel |=> (csr_rdata == '0));
  // R3: the error summary is never set with no error flag behind it
  p_err_r3: assert property (@(posedge clk) disable iff (rst)
    (csr_sel && (flags_q & ERR_MASK) == '0) |=> !csr_rdata[B_ERR]);
endmodule

// File: tb/netctl_csr_bench.sv
module netctl_csr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, we = 1'b0;
  logic [15:0] wd = '0;
  logic [6:0]  evs = '0;
  logic        ack = 1'b0, fatal = 1'b0, rxd = 1'b0, txd = 1'b0;
  logic [15:0] rdata;
  logic        c_init, c_start, c_stop, c_tdmd, rx_en, tx_en, irq, cfg;

  always #2.5 clk = ~clk;

  netctl_csr u_netctl_csr (
    .clk(clk), .rst(rst), .csr_sel(sel), .csr_we(we), .csr_wdata(wd),
    .csr_rdata(rdata),
    .ev_babble(evs[6]), .ev_hb_fail(evs[5]), .ev_missed(evs[4]),
    .ev_mem_timeout(evs[3]), .ev_rx_done(evs[2]), .ev_tx_done(evs[1]),
    .ev_init_done(evs[0]), .ev_tdmd_ack(ack), .ev_tx_fatal(fatal),
    .rx_disable(rxd), .tx_disable(txd),
    .cmd_init(c_init), .cmd_start(c_start), .cmd_stop(c_stop),
    .cmd_tdmd(c_tdmd), .rx_enable(rx_en), .tx_enable(tx_en),
    .irq(irq), .cfg_access(cfg)
  );

  int vectors = 0, fails = 0, cyc = 0;
  bit live = 0, done = 0;

  // behavioural model; flags[6:0] = babble..init done as in bits 14:8
  logic [6:0]  m_fl = '0;
  logic        m_inea = 0, m_rx = 0, m_tx = 0, m_tdmd = 0;
  logic        m_stop = 1, m_strt = 0, m_init = 0, m_both = 0, m_irq = 0;
  logic [15:0] m_rd = '0;

  function automatic logic m_err();
    return m_fl[6] | m_fl[5] | m_fl[4] | m_fl[3];
  endfunction
  function automatic logic m_intr();
    return m_fl[6] | m_fl[4] | m_fl[3] | m_fl[2] | m_fl[1] | m_fl[0];
  endfunction
  function automatic logic [15:0] m_word();
    return {m_err(), m_fl, m_intr(), m_inea, m_rx, m_tx, m_tdmd,
            m_stop, m_strt, m_init};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fl = '0; m_inea = 0; m_rx = 0; m_tx = 0; m_tdmd = 0;
      m_stop = 1; m_strt = 0; m_init = 0; m_both = 0; m_irq = 0; m_rd = '0;
    end else begin
      logic both_now, old_stop, wr;
      wr       = sel && we;
      m_rd     = sel ? m_word() : 16'h0;
      m_irq    = m_intr() && m_inea;
      both_now = m_strt && m_fl[0];
      old_stop = m_stop;
      if (m_fl[3]) begin
        m_rx = 0; m_tx = 0;
      end else begin
        if (both_now && !m_both) begin
          if (!rxd) m_rx = 1;
          if (!txd) m_tx = 1;
        end
        if (fatal) m_tx = 0;
      end
      m_both = both_now;
      if (wr && wd[2]) begin
        m_fl = '0; m_inea = 0; m_rx = 0; m_tx = 0; m_tdmd = 0;
        m_stop = 1; m_strt = 0; m_init = 0; m_both = 0;
      end else begin
        for (int i = 0; i < 7; i++) begin
          if (evs[i]) m_fl[i] = 1;
          else if (wr && wd[8+i]) m_fl[i] = 0;
        end
        if (wr) m_inea = wd[6];
        if (wr && wd[3]) m_tdmd = 1;
        else if (ack) m_tdmd = 0;
        if (wr && old_stop && (wd[0] || wd[1])) begin
          if (wd[0]) m_init = 1;
          if (wd[1]) m_strt = 1;
          m_stop = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R2 read word", rdata, m_rd);
      chk("R3 error summary", {15'h0, rdata[15]}, {15'h0, m_rd[15]});
      chk("R4 interrupt summary", {15'h0, rdata[7]}, {15'h0, m_rd[7]});
      chk("R6 flags", {9'h0, rdata[14:8]}, {9'h0, m_rd[14:8]});
      chk("R5 irq", {15'h0, irq}, {15'h0, m_irq});
      chk("R9 R10 link enables", {14'h0, rx_en, tx_en}, {14'h0, m_rx, m_tx});
      chk("R7 R8 commands", {13'h0, c_stop, c_start, c_init},
          {13'h0, m_stop, m_strt, m_init});
      chk("R11 transmit demand", {15'h0, c_tdmd}, {15'h0, m_tdmd});
      chk("R12 config access", {15'h0, cfg}, {15'h0, m_stop});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic drive(input logic s, input logic w, input logic [15:0] d,
                       input logic [6:0] e, input logic a, input logic f);
    sel = s; we = w; wd = d; evs = e; ack = a; fatal = f;
    @(negedge clk);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 16'h0, 7'h0, 0, 0);
  endtask
  task automatic wr(input logic [15:0] d); drive(1, 1, d, 7'h0, 0, 0); endtask
  task automatic rd(); drive(1, 0, 16'h0, 7'h0, 0, 0); endtask
  task automatic ev(input logic [6:0] e); drive(0, 0, 16'h0, e, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the pins
    chk("R1 reset outputs", {8'h0, c_init, c_start, c_stop, c_tdmd, rx_en, tx_en, irq, cfg},
        16'h0021);
    live = 1;
    rd(); chk("R1 reset word", rdata, 16'h0004);
    idle(1);
    wr(16'h0040);                  // enable interrupts
    ev(7'b1000000); idle(2); rd(); // babble: ERR, INTR, irq
    wr(16'h4040); idle(1);         // R6 clear babble
    ev(7'b0100000); idle(1); rd(); // R4 heartbeat alone: no INTR
    drive(1, 1, 16'h2040, 7'b0100000, 0, 0); rd(); // R6 event wins over clear
    wr(16'h0040); rd();            // R6 write 0 keeps flag
    wr(16'h2000); rd();
    ev(7'b0000001); idle(1);
    wr(16'h0002); idle(3); rd();   // R9 start after init done
    ev(7'b0001000); idle(2); rd(); // R10 memory timeout
    wr(16'h0008); idle(2);
    drive(0, 0, 16'h0, 7'h0, 1, 0); idle(1); // R11 acknowledge
    wr(16'h0007); idle(1); rd();   // R7 stop wins
    wr(16'h0001); ev(7'b0000001);
    wr(16'h0002); idle(2); rd();   // R8 start ignored when not stopped
    wr(16'h0004);
    rxd = 1; ev(7'b0000001); wr(16'h0002); idle(3); rxd = 0; rd();
    drive(0, 0, 16'h0, 7'h0, 0, 1); rd(); // R10 transmit fatal
    wr(16'h0004); rd();
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (d[2] && ($urandom % 6 != 0)) d[2] = 1'b0;
      rxd = ($urandom % 4 == 0);
      txd = ($urandom % 4 == 0);
      drive($urandom % 3 == 0, $urandom % 2 == 0, d,
            7'($urandom & $urandom & $urandom),
            $urandom % 4 == 0, $urandom % 32 == 0);
    end
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule